// File: doc/BRIEF.md
# Cascaded Codec Channel Serial Port

This block is the serial port of one channel in a chain of identical codec channels. Words travel down the chain on a single data line with a companion frame-sync line. Each channel receives on `sdi`/`sdi_fs` and retransmits on `sdo`/`sdo_fs`. Every word is 16 bits, sent MSB first. The frame-sync pulse lasts one clock and lines up with the first bit of the word.

The port starts in program mode. In this mode a received word with bit 15 set is a control word with this layout:

| Bits | Field |
|------|-------|
| 15 | control flag |
| 14:12 | relative address |
| 11 | write enable |
| 10:8 | register select |
| 7:0 | data |

Each hop lowers a nonzero address by one and passes the word on. The channel whose copy arrives with address zero takes the word for itself.

Register 0 is the mode register. Bit 0 selects data mode. Bits 3:1 hold the cascade length. Once data mode is set, every received word is a DAC sample. The port counts the words it receives. The word that brings the count to the cascade length goes into the DAC holding register, and every other word passes downstream.

On a sampling event the parallel ADC input is launched downstream as a word. This lets a controller at the end of the chain collect one ADC word per channel.

Top module: `dsc_port`

## Requirements
- R1: After reset the port is in program mode (`data_mode` = 0). All eight control registers on `cfg_q` read zero, `dac_q` is zero, `dac_load` is low, and `sdo`/`sdo_fs` stay low while nothing is sent.
- R2: A `sample` pulse with the transmitter idle captures `adc_in`. `sdo_fs` is high for exactly the one cycle after that clock edge. In that same cycle `sdo` carries bit 15 of the captured word, and the following cycles carry bits 14 down to 0.
- R3: In program mode, a received word with bit 15 set and a nonzero address in bits 14:12 is retransmitted with the address lowered by one and all other bits unchanged. Its `sdo_fs` starts in the cycle after the last input bit.
- R4: In program mode, a received word with bit 15 set, address zero and bit 11 set writes bits 7:0 into the register selected by bits 10:8. Register n appears on `cfg_q[8n+7:8n]`, and the word is not retransmitted.
- R5: In program mode, a received word with bit 15 set, address zero and bit 11 clear changes no register and is not retransmitted.
- R6: In program mode, a received word with bit 15 clear is retransmitted unchanged.
- R7: Writing a 1 into bit 0 of register 0 moves the port into data mode (`data_mode` = 1). Data mode holds until reset, and no later word changes a control register.
- R8: In data mode each completed input word increments a count. When the count equals bits 3:1 of register 0 (a field value of 0 stands for 8), the word goes into `dac_q`, `dac_load` pulses for one cycle and the count returns to zero.
- R9: In data mode every received word that does not complete the count is retransmitted unchanged, even when its bit 15 is set.
- R10: When a word to be retransmitted and a sampling event fall on the same clock edge, the retransmitted word goes first. The ADC word follows back to back, and each word has its own one-cycle `sdo_fs`.
- R11: A `sample` pulse that arrives while an earlier ADC word is still waiting for the transmitter is ignored.
- R12: An `sdi_fs` pulse in the middle of a word discards the partial word and starts a new reception at that bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sdi | input | 1 | Serial data from upstream |
| sdi_fs | input | 1 | Input frame sync, marks bit 15 |
| sdo | output | 1 | Serial data to downstream |
| sdo_fs | output | 1 | Output frame sync, marks bit 15 |
| sample | input | 1 | Sampling event pulse |
| adc_in | input | 16 | Parallel ADC word |
| dac_q | output | 16 | DAC holding register |
| dac_load | output | 1 | One-cycle pulse when `dac_q` is loaded |
| data_mode | output | 1 | 1 when in data mode |
| cfg_q | output | 64 | Eight 8-bit control registers, register 0 in the low byte |

## Verification
A sampling event and the completion of a word that must be retransmitted can land on the same clock edge. Both then compete for the one transmitter. The bench provokes this by raising `sample` in the same cycle that the sixteenth bit of a forwarded word arrives on `sdi`. It also provokes it by pulsing `sample` again while the deferred ADC word is still waiting. The outcome is judged from the word stream rebuilt from `sdo`/`sdo_fs`: the forwarded word first, the first ADC word right behind it, and no trace of the second sample.

// File: rtl/dsc_port.sv
module dsc_port #(
  parameter int W      = 16,
  parameter int ADDR_W = 3,
  parameter int SEL_W  = 3,
  parameter int DATA_W = 8
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           sdi,
  input  logic                           sdi_fs,
  output logic                           sdo,
  output logic                           sdo_fs,
  input  logic                           sample,
  input  logic [W-1:0]                   adc_in,
  output logic [W-1:0]                   dac_q,
  output logic                           dac_load,
  output logic                           data_mode,
  output logic [DATA_W*(1<<SEL_W)-1:0]   cfg_q
);
  localparam int NREG   = 1 << SEL_W;
  localparam int CNT_W  = $clog2(W + 1);
  localparam int A_HI   = W - 2;
  localparam int RW_B   = W - 2 - ADDR_W;
  localparam int SEL_HI = RW_B - 1;
  localparam int LOW_W  = W - 1 - ADDR_W;

  // receive
  logic [W-1:0]     rx_sh;
  logic [CNT_W-1:0] rx_n;
  wire              rx_done = !sdi_fs && (rx_n == CNT_W'(W - 1));
  wire  [W-1:0]     rx_word = {rx_sh[W-2:0], sdi};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_sh <= '0;
      rx_n  <= '0;
    end else if (sdi_fs) begin
      rx_sh <= rx_word;
      rx_n  <= CNT_W'(1);
    end else if (rx_n != '0) begin
      rx_sh <= rx_word;
      rx_n  <= rx_done ? '0 : rx_n + 1'b1;
    end
  end

  // decode
  logic [DATA_W-1:0] cfg [NREG];
  logic [ADDR_W-1:0] fs_cnt;

  wire              mode    = cfg[0][0];
  wire [ADDR_W-1:0] devn    = cfg[0][ADDR_W:1];
  wire [ADDR_W-1:0] fs_next = ADDR_W'(fs_cnt + 1'b1);
  wire [ADDR_W-1:0] addr    = rx_word[A_HI -: ADDR_W];
  wire [SEL_W-1:0]  sel     = rx_word[SEL_HI -: SEL_W];
  wire              is_ctl  = rx_word[W-1];

  wire take_dac = rx_done && mode && (fs_next == devn);
  wire take_reg = rx_done && !mode && is_ctl && (addr == '0);
  wire do_fwd   = rx_done && !take_dac && !take_reg;
  wire [W-1:0] fwd_word = (!mode && is_ctl)
                        ? {1'b1, ADDR_W'(addr - 1'b1), rx_word[LOW_W-1:0]}
                        : rx_word;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) cfg[i] <= '0;
    end else if (take_reg && rx_word[RW_B]) begin
      cfg[sel] <= rx_word[DATA_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fs_cnt   <= '0;
      dac_q    <= '0;
      dac_load <= 1'b0;
    end else begin
      dac_load <= take_dac;
      if (rx_done && mode) fs_cnt <= take_dac ? '0 : fs_next;
      if (take_dac) dac_q <= rx_word;
    end
  end

  // transmit
  logic [W-1:0]     tx_sh, fwd_hold, adc_hold;
  logic [CNT_W-1:0] tx_cnt;
  logic             fwd_wait, adc_wait, fs_q;

  wire         tx_free = tx_cnt <= CNT_W'(1);
  wire         fwd_any = do_fwd || fwd_wait;
  wire [W-1:0] fwd_src = do_fwd ? fwd_word : fwd_hold;
  wire [W-1:0] adc_src = adc_wait ? adc_hold : adc_in;
  wire         ld_fwd  = fwd_any && tx_free;
  wire         ld_adc  = !fwd_any && (adc_wait || sample) && tx_free;
  wire         adc_cap = sample && (adc_wait == ld_adc);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_sh    <= '0;
      tx_cnt   <= '0;
      fs_q     <= 1'b0;
      fwd_wait <= 1'b0;
      fwd_hold <= '0;
      adc_wait <= 1'b0;
      adc_hold <= '0;
    end else begin
      fs_q <= ld_fwd || ld_adc;
      if (ld_fwd || ld_adc) begin
        tx_sh  <= ld_fwd ? fwd_src : adc_src;
        tx_cnt <= CNT_W'(W);
      end else if (tx_cnt != '0) begin
        tx_sh  <= {tx_sh[W-2:0], 1'b0};
        tx_cnt <= tx_cnt - 1'b1;
      end
      fwd_wait <= fwd_any && !tx_free;
      if (do_fwd && !tx_free) fwd_hold <= fwd_word;
      adc_wait <= (adc_wait && !ld_adc) || adc_cap;
      if (adc_cap) adc_hold <= adc_in;
    end
  end

  assign sdo       = (tx_cnt != '0) && tx_sh[W-1];
  assign sdo_fs    = fs_q;
  assign data_mode = mode;

  for (genvar g = 0; g < NREG; g++) begin : g_cfg
    assign cfg_q[g*DATA_W +: DATA_W] = cfg[g];
  end
endmodule

// File: rtl/dsc_port_chk.sv
module dsc_port_chk #(
  parameter int W      = 16,
  parameter int ADDR_W = 3,
  parameter int SEL_W  = 3,
  parameter int DATA_W = 8,
  parameter int CNT_W  = $clog2(W + 1)
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic                         sdo_fs,
  input logic [CNT_W-1:0]             tx_cnt,
  input logic                         data_mode,
  input logic                         dac_load,
  input logic [W-1:0]                 dac_q,
  input logic [ADDR_W-1:0]            fs_cnt,
  input logic [DATA_W*(1<<SEL_W)-1:0] cfg_q
);
  AST_FS_SINGLE:   assert property (@(posedge clk) disable iff (!rst_n) sdo_fs |=> !sdo_fs);                      // R2
  AST_FS_FULL:     assert property (@(posedge clk) disable iff (!rst_n) sdo_fs |-> tx_cnt == CNT_W'(W));          // R3
  AST_MODE_HOLD:   assert property (@(posedge clk) disable iff (!rst_n) data_mode |=> data_mode);                 // R7
  AST_CFG_FROZEN:  assert property (@(posedge clk) disable iff (!rst_n) data_mode |=> $stable(cfg_q));            // R7
  AST_DAC_IN_DATA: assert property (@(posedge clk) disable iff (!rst_n) dac_load |-> data_mode);                  // R8
  AST_CNT_CLEARED: assert property (@(posedge clk) disable iff (!rst_n) dac_load |-> fs_cnt == '0);               // R8
  AST_CNT_IDLE:    assert property (@(posedge clk) disable iff (!rst_n) !data_mode |-> fs_cnt == '0);             // R8
  AST_DAC_STABLE:  assert property (@(posedge clk) disable iff (!rst_n) !dac_load |-> $stable(dac_q));            // R8
endmodule

bind dsc_port dsc_port_chk #(.W(W), .ADDR_W(ADDR_W), .SEL_W(SEL_W), .DATA_W(DATA_W)) u_chk (.*);

// File: tb/tb_dsc_port.sv
module tb_dsc_port;
  logic        clk = 0, rst_n = 0, sdi = 0, sdi_fs = 0, sample = 0;
  logic [15:0] adc_in = '0;
  logic        sdo, sdo_fs, dac_load, data_mode;
  logic [15:0] dac_q;
  logic [63:0] cfg_q;

  dsc_port dut (.clk(clk), .rst_n(rst_n), .sdi(sdi), .sdi_fs(sdi_fs), .sdo(sdo), .sdo_fs(sdo_fs),
                .sample(sample), .adc_in(adc_in), .dac_q(dac_q), .dac_load(dac_load),
                .data_mode(data_mode), .cfg_q(cfg_q));

  always #2.5 clk = ~clk;

  int    n_run = 0, n_fail = 0, cyc = 0;
  string cur = "R1";

  // behavioural reference
  logic [15:0] m_rx, m_tx, m_dac, m_adc, w;
  int          m_rxn = 0, m_txn = 0, m_cnt = 0;
  logic        m_fs = 0, m_ld = 0, m_mode = 0, m_adcw = 0;
  logic [7:0]  m_cfg [8];
  logic [15:0] fwdq [$];

  always @(posedge clk) begin
    if (!rst_n) begin
      m_rxn = 0; m_txn = 0; m_cnt = 0; m_fs = 0; m_ld = 0; m_mode = 0; m_adcw = 0;
      m_dac = 0; m_tx = 0; fwdq.delete();
      foreach (m_cfg[i]) m_cfg[i] = 0;
    end else begin
      bit done, free, loaded;
      int dev;
      done = 0; loaded = 0; m_ld = 0;
      if (sdi_fs) begin m_rx = {15'd0, sdi}; m_rxn = 1; end
      else if (m_rxn > 0) begin
        m_rx = {m_rx[14:0], sdi}; m_rxn++;
        if (m_rxn == 16) begin done = 1; w = m_rx; m_rxn = 0; end
      end
      free = (m_txn <= 1);
      if (done) begin
        if (m_mode) begin
          dev = (m_cfg[0][3:1] == 0) ? 8 : m_cfg[0][3:1];
          m_cnt++;
          if (m_cnt == dev) begin m_dac = w; m_ld = 1; m_cnt = 0; end
          else fwdq.push_back(w);
        end else if (w[15] && w[14:12] == 0) begin
          if (w[11]) m_cfg[w[10:8]] = w[7:0];
        end else if (w[15]) fwdq.push_back({w[15], w[14:12] - 3'd1, w[11:0]});
        else fwdq.push_back(w);
      end
      m_mode = m_cfg[0][0];
      if (free && fwdq.size() > 0) begin
        m_tx = fwdq.pop_front(); loaded = 1;
        if (sample && !m_adcw) begin m_adcw = 1; m_adc = adc_in; end
      end else if (free && (m_adcw || sample)) begin
        m_tx = m_adcw ? m_adc : adc_in; loaded = 1;
        if (m_adcw && sample) m_adc = adc_in; else m_adcw = 0;
      end else if (sample && !m_adcw) begin
        m_adcw = 1; m_adc = adc_in;
      end
      if (loaded) begin m_txn = 16; m_fs = 1; end
      else begin m_fs = 0; if (m_txn > 0) begin m_tx = m_tx << 1; m_txn--; end end
    end
  end

  function automatic logic [63:0] m_cfgq();
    for (int i = 0; i < 8; i++) m_cfgq[i*8 +: 8] = m_cfg[i];
  endfunction

  // per-cycle comparison and output word collector
  logic [15:0] outq [$];
  logic [15:0] col;
  int          coln = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      logic e_sdo;
      e_sdo = (m_txn > 0) && m_tx[15];
      n_run++;
      if (sdo !== e_sdo || sdo_fs !== m_fs || dac_q !== m_dac || dac_load !== m_ld ||
          data_mode !== m_mode || cfg_q !== m_cfgq()) begin
        n_fail++;
        $display("FAIL %s cycle %0d: got sdo=%b fs=%b dac=%h ld=%b mode=%b cfg=%h exp sdo=%b fs=%b dac=%h ld=%b mode=%b cfg=%h",
                 cur, cyc, sdo, sdo_fs, dac_q, dac_load, data_mode, cfg_q,
                 e_sdo, m_fs, m_dac, m_ld, m_mode, m_cfgq());
      end
      if (sdo_fs) begin col = {15'd0, sdo}; coln = 1; end
      else if (coln > 0) begin
        col = {col[14:0], sdo}; coln++;
        if (coln == 16) begin outq.push_back(col); coln = 0; end
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      n_fail++;
      $display("FAIL watchdog: got cycle %0d exp under 20000", cyc);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  task automatic chk(string r, logic [63:0] got, logic [63:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h exp %h", r, got, exp);
    end
  endtask

  task automatic chk_out(string r, logic [15:0] exp);
    if (outq.size() == 0) chk(r, 64'hDEAD_0000, {48'd0, exp});
    else chk(r, {48'd0, outq.pop_front()}, {48'd0, exp});
  endtask

  task automatic idle(int n);
    repeat (n) begin @(negedge clk); sdi_fs = 0; sdi = 0; sample = 0; end
  endtask

  task automatic send(logic [15:0] v);
    for (int i = 15; i >= 0; i--) begin
      @(negedge clk); sdi_fs = (i == 15); sdi = v[i];
    end
  endtask

  task automatic pulse_sample(logic [15:0] v);
    @(negedge clk); sample = 1; adc_in = v;
    @(negedge clk); sample = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    idle(2);
    cur = "R1";
    chk("R1 mode", {63'd0, data_mode}, 0);
    chk("R1 cfg", cfg_q, 0);
    chk("R1 dac", {48'd0, dac_q}, 0);
    chk("R1 fs", {62'd0, sdo_fs, sdo}, 0);

    cur = "R2"; pulse_sample(16'hA5C3); idle(20);
    chk_out("R2 adc word", 16'hA5C3);

    cur = "R3"; send(16'hA8F1); idle(20);
    chk_out("R3 addr decremented", 16'h98F1);

    cur = "R4"; send(16'h8B5A); idle(20);
    chk("R4 reg3", {56'd0, cfg_q[31:24]}, 8'h5A);
    chk("R4 absorbed", outq.size(), 0);

    cur = "R5"; send(16'h8311); idle(20);
    chk("R5 reg3 kept", {56'd0, cfg_q[31:24]}, 8'h5A);
    chk("R5 absorbed", outq.size(), 0);

    cur = "R6"; send(16'h1234); idle(20);
    chk_out("R6 data word", 16'h1234);

    cur = "R10";
    fork
      send(16'h4321);
      begin repeat (15) @(negedge clk); @(negedge clk); sample = 1; adc_in = 16'h0F0F; end
    join
    @(negedge clk); sample = 0; sdi = 0;
    cur = "R11"; idle(4); pulse_sample(16'hBEEF); idle(40);
    chk_out("R10 forward first", 16'h4321);
    chk_out("R10 adc second", 16'h0F0F);
    chk("R11 second sample dropped", outq.size(), 0);

    cur = "R12";
    for (int i = 15; i >= 10; i--) begin @(negedge clk); sdi_fs = (i == 15); sdi = 1'b1; end
    send(16'h2468); idle(20);
    chk_out("R12 restarted word", 16'h2468);
    chk("R12 partial dropped", outq.size(), 0);

    cur = "R7"; send(16'h8805); idle(20);
    chk("R7 data mode", {63'd0, data_mode}, 1);
    chk("R7 no output", outq.size(), 0);

    cur = "R9"; send(16'hC001); idle(20);
    chk_out("R9 control-looking word forwarded", 16'hC001);
    cur = "R8"; send(16'h7777); idle(20);
    chk("R8 dac loaded", {48'd0, dac_q}, 16'h7777);
    chk("R8 not forwarded", outq.size(), 0);
    chk("R7 cfg frozen", {56'd0, cfg_q[7:0]}, 8'h05);

    cur = "R8"; send(16'h1111); send(16'h2222); idle(20);
    chk_out("R9 first of pair", 16'h1111);
    chk("R8 second of pair", {48'd0, dac_q}, 16'h2222);

    cur = "R2"; pulse_sample(16'h5A5A); idle(20);
    chk_out("R2 adc in data mode", 16'h5A5A);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule